// File: doc/BRIEF.md
# Maskable Content-Addressable Array with Entry Validity

This block holds a parameterized number of 64-bit entries. Each entry carries a two-bit validity state built from a Skip bit and an Empty bit. On request, the block compares a 64-bit search key against every entry at once and reports whether any entry matched. When one or more entries match, it also reports the lowest matching address. A compare can be limited by one of two software-loaded mask registers. The compare-control inputs also divide every entry into a searchable field and a storage-only field on 16-bit boundaries. The storage-only field can sit at either the low end or the high end of the word, and it never takes part in a compare.

There are two kinds of compare. A normal compare considers only entries in the Valid state. A forced compare names one validity state and searches only the entries in that state. A forced search for Empty ignores every data bit, so it finds the first free location. The array can also be read and written directly by address. A direct write can protect selected bits through either mask register, which makes read-modify-write of a partial field unnecessary. Command decoding and the host bus sit outside this block.

Top module: `vcam_array`

## Requirements
- R1: After reset, every entry holds data zero with state Empty, both mask registers are zero, `match_flag` is 0, `match_addr` is 0 and `rd_valid` is 0.
- R2: A direct write (`wr_en`) stores `wr_state` and `wr_data` at `wr_addr`. The write-protect select `wr_msel` uses 1 for mask A, 2 for mask B, and 0 or 3 for no protection. A data bit whose selected mask bit is 1 keeps its old value.
- R3: `rd_en` makes `rd_valid` high on the next cycle, with `rd_data` and `rd_state` equal to the entry as it stood before any write in the same cycle. With `rd_en` low, `rd_valid` is 0 on the next cycle.
- R4: `mreg_we` loads `mreg_data` into mask A when `mreg_sel` is 0 and into mask B when it is 1. The new value applies to compares and writes from the following cycle on.
- R5: A normal compare (`cmp_req` with `cmp_forced` low) considers only entries in state Valid (00). It posts its result on `match_flag` and `match_addr` one clock later.
- R6: `cmp_msel` chooses the compare mask: 1 for A, 2 for B, and 0 or 3 for none. Key bits whose mask bit is 1 are excluded from the equality test.
- R7: `split_code` gives the number n of 16-bit segments that are storage-only. The value saturates at 3. With `ram_high` low these are the n lowest segments, so code 001 leaves bits 63:16 searchable. With `ram_high` high they are the n highest segments. These bits are never compared.
- R8: A forced compare searches only entries whose state equals `cmp_cond`. States are encoded as {Skip, Empty}: 00 Valid, 10 Skip, 01 Empty, 11 storage-only.
- R9: A forced compare with `cmp_cond` = 01 (Empty) ignores every data bit and the mask, so it matches every Empty entry.
- R10: When several entries match, `match_addr` reports the lowest matching address.
- R11: A compare with no match drives `match_flag` low and leaves `match_addr` unchanged.
- R12: In a cycle without `cmp_req`, `match_flag` and `match_addr` keep their values.
- R13: A compare sees the array and the mask registers as they were before any write issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mreg_we | input | 1 | Mask register load strobe |
| mreg_sel | input | 1 | Mask register target: 0 = A, 1 = B |
| mreg_data | input | DATA_W | Mask register load value |
| wr_en | input | 1 | Direct entry write strobe |
| wr_addr | input | AW | Direct write address |
| wr_data | input | DATA_W | Direct write data |
| wr_state | input | 2 | Validity written with the entry ({Skip, Empty}) |
| wr_msel | input | 2 | Write-protect mask select |
| rd_en | input | 1 | Direct entry read strobe |
| rd_addr | input | AW | Direct read address |
| rd_data | output | DATA_W | Read data, registered |
| rd_state | output | 2 | Read validity, registered |
| rd_valid | output | 1 | Read result present |
| split_code | input | 3 | Number of storage-only segments |
| ram_high | input | 1 | Storage-only field at the high end |
| cmp_msel | input | 2 | Compare mask select |
| cmp_req | input | 1 | Start a compare |
| cmp_forced | input | 1 | Compare on the state in cmp_cond instead of Valid |
| cmp_cond | input | 2 | Validity state searched by a forced compare |
| comparand | input | DATA_W | Search key |
| match_flag | output | 1 | Some entry matched in the last compare |
| match_addr | output | AW | Lowest matching address |

## Verification
The bench builds the block with DEPTH = 8, DATA_W = 64 and SEG_W = 16. With only eight entries, directed tests can fill every location and can place matches at the first, middle and last positions. That makes every priority position and every mix of the four validity states reachable within a few hundred cycles. The 16-bit segment width gives four segments. As a result, every split code from 0 to 7, including the saturating codes, can be swept in both placements. A random phase then draws keys from a three-value pool per segment, so multi-entry hits and misses occur often.

// File: rtl/vcam_pkg.sv
`timescale 1ns/1ps
package vcam_pkg;

    // Entry validity, encoded {Skip, Empty}
    typedef enum logic [1:0] {
        ST_VALID = 2'b00,
        ST_EMPTY = 2'b01,
        ST_SKIP  = 2'b10,
        ST_STORE = 2'b11
    } vstate_e;

    // Mask select encodings shared by writes and compares
    localparam logic [1:0] MSEL_NONE = 2'b00;
    localparam logic [1:0] MSEL_A    = 2'b01;
    localparam logic [1:0] MSEL_B    = 2'b10;

endpackage

// File: rtl/vcam_care_gen.sv
`timescale 1ns/1ps
// Builds the per-bit "compare this bit" vector from the field split and the
// selected compare mask.
module vcam_care_gen #(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 16,
    localparam int NSEG  = DATA_W / SEG_W
) (
    input  logic [2:0]        split_code,
    input  logic              ram_high,
    input  logic [DATA_W-1:0] key_mask,
    output logic [DATA_W-1:0] care
);

    logic [NSEG-1:0] seg_store;
    int              n_store;

    always_comb begin
        n_store = (int'(split_code) > NSEG - 1) ? NSEG - 1 : int'(split_code);
        for (int s = 0; s < NSEG; s++) begin
            if (ram_high) seg_store[s] = (s >= NSEG - n_store);
            else          seg_store[s] = (s < n_store);
        end
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        assign care[s*SEG_W +: SEG_W] =
            {SEG_W{~seg_store[s]}} & ~key_mask[s*SEG_W +: SEG_W];
    end

endmodule

// File: rtl/vcam_entry_match.sv
`timescale 1ns/1ps
// One entry's comparator: state gate plus masked equality.
module vcam_entry_match #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] entry_data,
    input  logic [1:0]        entry_state,
    input  logic [DATA_W-1:0] key,
    input  logic [DATA_W-1:0] care,
    input  logic [1:0]        want_state,
    output logic              hit
);

    logic [DATA_W-1:0] diff;

    always_comb begin
        diff = (entry_data ^ key) & care;
        hit  = (entry_state == want_state) && (diff == '0);
    end

endmodule

// File: rtl/vcam_prio_enc.sv
`timescale 1ns/1ps
// Lowest-index-wins priority encoder.
module vcam_prio_enc #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic [DEPTH-1:0] hits,
    output logic             any,
    output logic [AW-1:0]    idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = AW'(i);
            end
        end
    end

endmodule

// File: rtl/vcam_array.sv
`timescale 1ns/1ps
module vcam_array
    import vcam_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 64,
    parameter int SEG_W  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mreg_we,
    input  logic              mreg_sel,
    input  logic [DATA_W-1:0] mreg_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        wr_state,
    input  logic [1:0]        wr_msel,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_state,
    output logic              rd_valid,
    input  logic [2:0]        split_code,
    input  logic              ram_high,
    input  logic [1:0]        cmp_msel,
    input  logic              cmp_req,
    input  logic              cmp_forced,
    input  logic [1:0]        cmp_cond,
    input  logic [DATA_W-1:0] comparand,
    output logic              match_flag,
    output logic [AW-1:0]     match_addr
);

    typedef struct packed {
        logic [DATA_W-1:0] mask_a;
        logic [DATA_W-1:0] mask_b;
        logic              flag;
        logic [AW-1:0]     addr;
        logic [DATA_W-1:0] rd_data;
        logic [1:0]        rd_state;
        logic              rd_valid;
    } regs_t;

    regs_t             r_d, r_q;
    logic [DATA_W-1:0] mem_data_d [DEPTH];
    logic [DATA_W-1:0] mem_data_q [DEPTH];
    logic [1:0]        mem_st_d   [DEPTH];
    logic [1:0]        mem_st_q   [DEPTH];

    // ---------------- compare path ----------------
    logic [DATA_W-1:0] key_mask;
    logic [DATA_W-1:0] field_care;
    logic [DATA_W-1:0] eff_care;
    logic [1:0]        want_state;
    logic [DEPTH-1:0]  hit_vec;
    logic              any_hit;
    logic [AW-1:0]     hit_idx;

    always_comb begin
        case (cmp_msel)
            MSEL_A:  key_mask = r_q.mask_a;
            MSEL_B:  key_mask = r_q.mask_b;
            default: key_mask = '0;
        endcase
    end

    vcam_care_gen #(
        .DATA_W (DATA_W),
        .SEG_W  (SEG_W)
    ) u_care (
        .split_code (split_code),
        .ram_high   (ram_high),
        .key_mask   (key_mask),
        .care       (field_care)
    );

    always_comb begin
        want_state = cmp_forced ? cmp_cond : ST_VALID;
        eff_care   = (cmp_forced && (cmp_cond == ST_EMPTY)) ? '0 : field_care;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        vcam_entry_match #(
            .DATA_W (DATA_W)
        ) u_match (
            .entry_data  (mem_data_q[g]),
            .entry_state (mem_st_q[g]),
            .key         (comparand),
            .care        (eff_care),
            .want_state  (want_state),
            .hit         (hit_vec[g])
        );
    end

    vcam_prio_enc #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_prio (
        .hits (hit_vec),
        .any  (any_hit),
        .idx  (hit_idx)
    );

    // ---------------- next-state ----------------
    logic [DATA_W-1:0] wr_prot;

    always_comb begin
        case (wr_msel)
            MSEL_A:  wr_prot = r_q.mask_a;
            MSEL_B:  wr_prot = r_q.mask_b;
            default: wr_prot = '0;
        endcase
    end

    always_comb begin
        r_d        = r_q;
        mem_data_d = mem_data_q;
        mem_st_d   = mem_st_q;

        if (mreg_we) begin
            if (mreg_sel) r_d.mask_b = mreg_data;
            else          r_d.mask_a = mreg_data;
        end

        if (wr_en && (int'(wr_addr) < DEPTH)) begin
            mem_data_d[wr_addr] = (mem_data_q[wr_addr] & wr_prot) |
                                  (wr_data & ~wr_prot);
            mem_st_d[wr_addr]   = wr_state;
        end

        r_d.rd_valid = rd_en;
        if (rd_en && (int'(rd_addr) < DEPTH)) begin
            r_d.rd_data  = mem_data_q[rd_addr];
            r_d.rd_state = mem_st_q[rd_addr];
        end

        if (cmp_req) begin
            r_d.flag = any_hit;
            if (any_hit) r_d.addr = hit_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_data_q[i] <= '0;
                mem_st_q[i]   <= ST_EMPTY;
            end
        end else begin
            r_q <= r_d;
            for (int i = 0; i < DEPTH; i++) begin
                mem_data_q[i] <= mem_data_d[i];
                mem_st_q[i]   <= mem_st_d[i];
            end
        end
    end

    assign rd_data    = r_q.rd_data;
    assign rd_state   = r_q.rd_state;
    assign rd_valid   = r_q.rd_valid;
    assign match_flag = r_q.flag;
    assign match_addr = r_q.addr;

endmodule

// File: rtl/vcam_array_chk.sv
`timescale 1ns/1ps
module vcam_array_chk #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmp_req,
    input logic             rd_en,
    input logic             rd_valid,
    input logic             match_flag,
    input logic [AW-1:0]    match_addr,
    input logic [DEPTH-1:0] hit_vec
);

    assert_rd_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_rd_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_flag_from_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_req |=> (match_flag == $past(|hit_vec)));

    assert_lowest_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && hit_vec[0]) |=> (match_flag && (match_addr == '0)));

    assert_miss_holds_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && (hit_vec == '0)) |=> (!match_flag && $stable(match_addr)));

    assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_req |=> ($stable(match_flag) && $stable(match_addr)));

endmodule

bind vcam_array vcam_array_chk #(
    .DEPTH (DEPTH),
    .AW    (AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_req    (cmp_req),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .match_flag (match_flag),
    .match_addr (match_addr),
    .hit_vec    (hit_vec)
);

// File: tb/vcam_array_tb.sv
`timescale 1ns/1ps
module vcam_array_tb;

    localparam int D  = 8;
    localparam int W  = 64;
    localparam int A  = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mreg_we = 0, mreg_sel = 0;
    logic [W-1:0] mreg_data = '0;
    logic         wr_en = 0;
    logic [A-1:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   wr_state = 2'b00, wr_msel = 2'b00;
    logic         rd_en = 0;
    logic [A-1:0] rd_addr = '0;
    logic [W-1:0] rd_data;
    logic [1:0]   rd_state;
    logic         rd_valid;
    logic [2:0]   split_code = 3'd0;
    logic         ram_high = 0;
    logic [1:0]   cmp_msel = 2'b00;
    logic         cmp_req = 0, cmp_forced = 0;
    logic [1:0]   cmp_cond = 2'b00;
    logic [W-1:0] comparand = '0;
    logic         match_flag;
    logic [A-1:0] match_addr;

    always #10 clk = ~clk;

    vcam_array #(.DEPTH(D), .DATA_W(W), .SEG_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .mreg_we(mreg_we), .mreg_sel(mreg_sel), .mreg_data(mreg_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_state(wr_state), .wr_msel(wr_msel),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_state(rd_state), .rd_valid(rd_valid),
        .split_code(split_code), .ram_high(ram_high), .cmp_msel(cmp_msel),
        .cmp_req(cmp_req), .cmp_forced(cmp_forced), .cmp_cond(cmp_cond),
        .comparand(comparand), .match_flag(match_flag), .match_addr(match_addr)
    );

    // ---------------- reference model ----------------
    logic [W-1:0] m_data [D];
    logic [1:0]   m_st   [D];
    logic [W-1:0] m_ma, m_mb;
    logic         e_flag, e_rvld;
    logic [A-1:0] e_addr;
    logic [W-1:0] e_rdata;
    logic [1:0]   e_rst;

    int    n_vec = 0, n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    task automatic model_reset();
        for (int i = 0; i < D; i++) begin m_data[i] = '0; m_st[i] = 2'b01; end
        m_ma = '0; m_mb = '0;
        e_flag = 0; e_addr = '0; e_rvld = 0; e_rdata = '0; e_rst = 2'b00;
    endtask

    function automatic logic [W-1:0] pick_mask(logic [1:0] sel);
        if (sel == 2'b01) return m_ma;
        if (sel == 2'b10) return m_mb;
        return '0;
    endfunction

    function automatic bit ref_hit(int i);
        logic [1:0]   want;
        logic [W-1:0] msk;
        int           nram, seg;
        bit           is_store;
        want = cmp_forced ? cmp_cond : 2'b00;
        if (m_st[i] != want) return 0;
        if (cmp_forced && cmp_cond == 2'b01) return 1;
        msk  = pick_mask(cmp_msel);
        nram = (split_code > 3) ? 3 : int'(split_code);
        for (int b = 0; b < W; b++) begin
            seg = b / 16;
            is_store = ram_high ? (seg >= 4 - nram) : (seg < nram);
            if (!is_store && !msk[b] && (m_data[i][b] != comparand[b])) return 0;
        end
        return 1;
    endfunction

    task automatic model_step();
        bit found;
        logic [W-1:0] prot;
        if (cmp_req) begin
            found = 0;
            for (int i = 0; i < D; i++)
                if (!found && ref_hit(i)) begin found = 1; e_addr = A'(i); end
            e_flag = found;
        end
        e_rvld = rd_en;
        if (rd_en) begin e_rdata = m_data[rd_addr]; e_rst = m_st[rd_addr]; end
        prot = pick_mask(wr_msel);
        if (wr_en) begin
            m_data[wr_addr] = (m_data[wr_addr] & prot) | (wr_data & ~prot);
            m_st[wr_addr]   = wr_state;
        end
        if (mreg_we) begin
            if (mreg_sel) m_mb = mreg_data; else m_ma = mreg_data;
        end
    endtask

    task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("match_flag", W'(match_flag), W'(e_flag));
        chk("match_addr", W'(match_addr), W'(e_addr));
        chk("rd_valid", W'(rd_valid), W'(e_rvld));
        if (e_rvld) begin
            chk("rd_data", rd_data, e_rdata);
            chk("rd_state", W'(rd_state), W'(e_rst));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        mreg_we = 0; wr_en = 0; rd_en = 0; cmp_req = 0;
        cmp_forced = 0; wr_msel = 2'b00;
    endtask

    task automatic do_write(int a, logic [W-1:0] d, logic [1:0] st, logic [1:0] ms);
        idle_inputs();
        wr_en = 1; wr_addr = A'(a); wr_data = d; wr_state = st; wr_msel = ms;
        tick(); idle_inputs();
    endtask

    task automatic do_read(int a);
        idle_inputs(); rd_en = 1; rd_addr = A'(a); tick(); idle_inputs();
    endtask

    task automatic do_mask(bit sel, logic [W-1:0] v);
        idle_inputs(); mreg_we = 1; mreg_sel = sel; mreg_data = v; tick(); idle_inputs();
    endtask

    task automatic do_cmp(logic [W-1:0] key, bit forced, logic [1:0] cond, logic [1:0] ms);
        idle_inputs();
        cmp_req = 1; comparand = key; cmp_forced = forced; cmp_cond = cond; cmp_msel = ms;
        tick(); idle_inputs();
    endtask

    function automatic logic [W-1:0] rkey();
        logic [15:0] pool [3] = '{16'h0000, 16'hFFFF, 16'h1234};
        logic [W-1:0] k;
        for (int s = 0; s < 4; s++) k[s*16 +: 16] = pool[$urandom % 3];
        return k;
    endfunction

    localparam logic [W-1:0] KEY = 64'hA5A5_1234_5678_9ABC;

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on the outputs and in every entry
        cur_req = "R1";
        compare_all();
        for (int i = 0; i < D; i++) do_read(i);

        // R2: plain and protected direct writes
        cur_req = "R2";
        for (int i = 0; i < D; i++) do_write(i, {32'h0, 32'(i)} * 64'h0101_0101_0101, 2'b10, 2'b00);
        for (int i = 0; i < D; i++) do_read(i);
        // R4: mask loads
        cur_req = "R4";
        do_mask(0, 64'hFFFF_0000_0000_0000);
        do_mask(1, 64'h0000_0000_0000_FFFF);
        cur_req = "R2";
        do_write(3, 64'hDEAD_BEEF_CAFE_F00D, 2'b00, 2'b01);
        do_read(3);
        do_write(4, 64'hDEAD_BEEF_CAFE_F00D, 2'b00, 2'b10);
        do_read(4);
        do_write(5, 64'hDEAD_BEEF_CAFE_F00D, 2'b00, 2'b11);
        do_read(5);

        // R3: read and write to the same entry in one cycle returns old data
        cur_req = "R3";
        idle_inputs();
        wr_en = 1; wr_addr = 3'd6; wr_data = 64'h1111_2222_3333_4444; wr_state = 2'b11;
        rd_en = 1; rd_addr = 3'd6;
        tick(); idle_inputs();
        do_read(6);

        // R5 / R10: normal compare, several valid hits
        cur_req = "R5";
        for (int i = 0; i < D; i++) do_write(i, 64'h0, 2'b01, 2'b00);
        do_write(1, KEY, 2'b10, 2'b00);
        do_write(2, KEY, 2'b00, 2'b00);
        do_write(5, KEY, 2'b00, 2'b00);
        do_write(7, KEY, 2'b11, 2'b00);
        do_cmp(KEY, 0, 2'b00, 2'b00);
        cur_req = "R10";
        do_cmp(KEY, 0, 2'b00, 2'b00);
        do_write(2, KEY, 2'b10, 2'b00);
        do_cmp(KEY, 0, 2'b00, 2'b00);
        // R12: outputs hold without a request
        cur_req = "R12";
        repeat (3) tick();
        // R11: miss keeps address
        cur_req = "R11";
        do_cmp(KEY ^ 64'h1, 0, 2'b00, 2'b00);
        repeat (2) tick();

        // R6: compare masks
        cur_req = "R6";
        do_cmp(KEY ^ 64'h0000_0000_0000_00FF, 0, 2'b00, 2'b10);
        do_cmp(KEY ^ 64'h0000_0000_0000_00FF, 0, 2'b00, 2'b01);
        do_cmp(KEY ^ 64'h00FF_0000_0000_0000, 0, 2'b00, 2'b01);
        do_cmp(KEY ^ 64'h00FF_0000_0000_0000, 0, 2'b00, 2'b11);

        // R7: every split code, both placements
        cur_req = "R7";
        for (int c = 0; c < 8; c++) begin
            for (int h = 0; h < 2; h++) begin
                split_code = 3'(c); ram_high = h[0];
                do_cmp(KEY ^ 64'h0000_0000_0000_0F00, 0, 2'b00, 2'b00);
                do_cmp(KEY ^ 64'h0F00_0000_0000_0000, 0, 2'b00, 2'b00);
                do_cmp(KEY ^ 64'h0000_0F00_0F00_0000, 0, 2'b00, 2'b00);
            end
        end
        split_code = 3'd0; ram_high = 0;

        // R8: forced compares on each state
        cur_req = "R8";
        for (int cnd = 0; cnd < 4; cnd++) begin
            do_cmp(KEY, 1, 2'(cnd), 2'b00);
            do_cmp(64'h0, 1, 2'(cnd), 2'b00);
        end

        // R9: Empty search ignores data and mask
        cur_req = "R9";
        do_cmp(64'hFFFF_FFFF_FFFF_FFFF, 1, 2'b01, 2'b01);
        do_write(0, 64'h55, 2'b00, 2'b00);
        do_cmp(64'h1234_0000_0000_0000, 1, 2'b01, 2'b00);

        // R13: compare in the same cycle as an entry write and a mask load
        cur_req = "R13";
        idle_inputs();
        cmp_req = 1; comparand = 64'h55; cmp_msel = 2'b00;
        wr_en = 1; wr_addr = 3'd0; wr_data = 64'h66; wr_state = 2'b00;
        tick(); idle_inputs();
        do_cmp(64'h55, 0, 2'b00, 2'b00);
        idle_inputs();
        cmp_req = 1; comparand = 64'h67; cmp_msel = 2'b01;
        mreg_we = 1; mreg_sel = 0; mreg_data = 64'h1;
        tick(); idle_inputs();
        do_cmp(64'h67, 0, 2'b00, 2'b01);

        // Random mix across all requirements
        cur_req = "R5";
        for (int n = 0; n < 600; n++) begin
            wr_en      = ($urandom % 10) < 4;
            wr_addr    = A'($urandom);
            wr_data    = rkey();
            wr_state   = 2'($urandom);
            wr_msel    = 2'($urandom);
            rd_en      = ($urandom % 10) < 3;
            rd_addr    = A'($urandom);
            mreg_we    = ($urandom % 10) == 0;
            mreg_sel   = 1'($urandom);
            mreg_data  = {{16{1'($urandom)}}, {16{1'($urandom)}}, {16{1'($urandom)}}, {16{1'($urandom)}}};
            cmp_req    = ($urandom % 2) == 1;
            cmp_forced = ($urandom % 10) < 3;
            cmp_cond   = 2'($urandom);
            cmp_msel   = 2'($urandom);
            comparand  = rkey();
            split_code = 3'($urandom);
            ram_high   = 1'($urandom);
            tick();
        end
        idle_inputs();
        tick();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule